// File: doc/BRIEF.md
# Oscillator Trim Calibration Controller

This block holds the 5-bit frequency-trim code of an on-chip RC oscillator and nudges it one step at a time from error evidence. The trim code is two's-complement. Zero is the calibrated centre, the largest positive value is the fastest setting and the most negative value is the slowest. The code saturates at both ends.

Evidence comes from one of two sources, selected by `mode_timer`:

- **Serial-receiver mode.** The block reads the receiver's framing-error and data-error flags.
- **Timer mode.** A device-clock counter is compared against a reference window made of `WIN_LEN` reference ticks. The ticks arrive as single-cycle pulses already brought into the device clock domain.

The block also presents an 8-bit configuration view that software can write. Bit 7 selects the low-frequency source: the internal source divided by 256 when 1, a separate low-power oscillator when 0. Bit 6 requests the frequency-multiplier PLL. Bit 5 always reads as 0. Bits 4:0 hold the trim code.

Top module: `osctrim_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the trim code, the low-frequency select bit and the PLL request bit all clear, so `cfg_rdata` reads 8'h00.
- R2: In serial-receiver mode (`mode_timer`=0), a cycle with `rx_frame_err`=1 lowers the trim code by one at that clock edge.
- R3: In serial-receiver mode, a cycle with `rx_data_err`=1 and `rx_frame_err`=0 raises the trim code by one at that clock edge.
- R4: When both error flags are high in the same cycle, only the framing error acts: a single decrement.
- R5: Steps saturate. An increment at 5'b01111 and a decrement at 5'b10000 leave the code unchanged; no step ever wraps.
- R6: In timer mode, the device counter counts every cycle and the reference counter counts `ref_tick` pulses. The window closes on the cycle that carries the `WIN_LEN`-th tick. The device count for that window includes the closing cycle. Both counters restart on the next cycle.
- R7: At the close of a timer window, the trim steps down when the count is above `TARGET+TOL`, steps up when it is below `TARGET-TOL`, and holds otherwise. The device count saturates at all ones.
- R8: Mode isolation. In timer mode the receiver flags have no effect. In serial-receiver mode both counters are held at zero, so `ref_tick` has no effect.
- R9: A cycle with `cfg_wr`=1 loads `cfg_wdata[7]`, `cfg_wdata[6]` and `cfg_wdata[4:0]`, and overrides any automatic step in that cycle. `cfg_rdata` is {lf-select, PLL request, 0, trim}, and bit 5 always reads 0.
- R10: `pll_active` is high only when the PLL request bit is 1 and `hf_sel` is 3'd6 (4 MHz) or 3'd7 (8 MHz).
- R11: `lf_use_div` equals the low-frequency select bit and changes only on a write, never because of a trim step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_timer | input | 1 | 1 = timer-comparison evidence, 0 = receiver-flag evidence |
| rx_frame_err | input | 1 | Receiver framing error (clock too fast) |
| rx_data_err | input | 1 | Receiver data error (clock too slow) |
| ref_tick | input | 1 | One-cycle pulse per reference-clock edge |
| cfg_wr | input | 1 | Software write strobe |
| cfg_wdata | input | 8 | Software write data |
| hf_sel | input | 3 | Current internal-oscillator frequency code |
| trim_code | output | 5 | Signed trim code to the oscillator |
| cfg_rdata | output | 8 | Configuration view |
| pll_active | output | 1 | PLL actually enabled |
| lf_use_div | output | 1 | Low-frequency clock taken from the divided internal source |

## Verification
Receiver flags are driven as isolated framing errors, isolated data errors and coincident pairs. These cases separate the decrement path, the increment path and the priority between them. Writes to 01111 and 10000, each followed by repeated errors, expose any wrap at the saturation limits.

In timer mode, reference ticks arrive with periods of 3, 4 and 5 cycles. These produce counts below, inside and above the tolerance band, so each of the three decisions is tested on its own.

Long random runs then mix:
- mode switches,
- writes that coincide with error flags,
- flags raised in the wrong mode,
- random frequency codes.

These runs show that writes win, that the inactive source is ignored, that the PLL gating is correct, and that the low-frequency select bit stays put while the trim moves.

// File: rtl/osctrim_pkg.sv
package osctrim_pkg;

    localparam int TRIM_W = 5;
    localparam int HF_W   = 3;

    localparam logic [HF_W-1:0] HF_CODE_4MHZ = 3'd6;
    localparam logic [HF_W-1:0] HF_CODE_8MHZ = 3'd7;

    typedef logic signed [TRIM_W-1:0] trim_t;

    localparam trim_t TRIM_MAX = trim_t'({1'b0, {(TRIM_W-1){1'b1}}});
    localparam trim_t TRIM_MIN = trim_t'({1'b1, {(TRIM_W-1){1'b0}}});

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    typedef struct packed {
        logic  lf_div;
        logic  pll_en;
        trim_t trim;
    } cfg_t;

    function automatic trim_t sat_step(trim_t cur, step_e s);
        trim_t nxt;
        nxt = cur;
        case (s)
            STEP_UP:   if (cur != TRIM_MAX) nxt = cur + trim_t'(1);
            STEP_DOWN: if (cur != TRIM_MIN) nxt = cur - trim_t'(1);
            default:   nxt = cur;
        endcase
        return nxt;
    endfunction

    function automatic logic [7:0] pack_view(cfg_t c);
        return {c.lf_div, c.pll_en, 1'b0, c.trim};
    endfunction

    function automatic logic pll_allowed(logic [HF_W-1:0] hf);
        return (hf == HF_CODE_4MHZ) || (hf == HF_CODE_8MHZ);
    endfunction

endpackage

// File: rtl/osctrim_uart_eval.sv
module osctrim_uart_eval
    import osctrim_pkg::*;
(
    input  logic  enable,
    input  logic  frame_err,
    input  logic  data_err,
    output step_e step
);
    always_comb begin
        step = STEP_HOLD;
        if (enable) begin
            if (frame_err)     step = STEP_DOWN;
            else if (data_err) step = STEP_UP;
        end
    end
endmodule

// File: rtl/osctrim_ref_meter.sv
module osctrim_ref_meter
    import osctrim_pkg::*;
#(
    parameter int WIN_LEN = 16,
    parameter int TARGET  = 64,
    parameter int TOL     = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  enable,
    input  logic  ref_tick,
    output step_e step
);
    localparam int CNT_W = $clog2(4 * TARGET);
    localparam int REF_W = $clog2(WIN_LEN + 1);
    localparam logic [CNT_W-1:0] DEV_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] HI_LIM  = CNT_W'(TARGET + TOL);
    localparam logic [CNT_W-1:0] LO_LIM  = CNT_W'(TARGET - TOL);
    localparam logic [REF_W-1:0] REF_END = REF_W'(WIN_LEN - 1);

    logic [CNT_W-1:0] dev_cnt, dev_next;
    logic [REF_W-1:0] ref_cnt;
    logic             win_end;

    assign dev_next = (dev_cnt == DEV_MAX) ? dev_cnt : dev_cnt + CNT_W'(1);
    assign win_end  = enable && ref_tick && (ref_cnt == REF_END);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            dev_cnt <= '0;
            ref_cnt <= '0;
        end else if (win_end) begin
            dev_cnt <= '0;
            ref_cnt <= '0;
        end else begin
            dev_cnt <= dev_next;
            if (ref_tick) ref_cnt <= ref_cnt + REF_W'(1);
        end
    end

    always_comb begin
        step = STEP_HOLD;
        if (win_end) begin
            if (dev_next > HI_LIM)      step = STEP_DOWN;
            else if (dev_next < LO_LIM) step = STEP_UP;
        end
    end
endmodule

// File: rtl/osctrim_trim_reg.sv
module osctrim_trim_reg
    import osctrim_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  cfg_t  wr_cfg,
    input  step_e step,
    output cfg_t  cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            cfg <= wr_cfg;
        end else begin
            cfg.trim <= sat_step(cfg.trim, step);
        end
    end
endmodule

// File: rtl/osctrim_ctrl.sv
module osctrim_ctrl
    import osctrim_pkg::*;
#(
    parameter int WIN_LEN = 16,
    parameter int TARGET  = 64,
    parameter int TOL     = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_timer,
    input  logic       rx_frame_err,
    input  logic       rx_data_err,
    input  logic       ref_tick,
    input  logic       cfg_wr,
    input  logic [7:0] cfg_wdata,
    input  logic [2:0] hf_sel,
    output logic [4:0] trim_code,
    output logic [7:0] cfg_rdata,
    output logic       pll_active,
    output logic       lf_use_div
);
    step_e uart_step, timer_step, sel_step;
    cfg_t  cfg_q, wr_cfg;
    logic  wdata_unused;

    assign wdata_unused = cfg_wdata[5];
    assign wr_cfg = '{lf_div: cfg_wdata[7], pll_en: cfg_wdata[6],
                      trim: trim_t'(cfg_wdata[4:0])};

    osctrim_uart_eval u_uart (
        .enable    (!mode_timer),
        .frame_err (rx_frame_err),
        .data_err  (rx_data_err),
        .step      (uart_step)
    );

    osctrim_ref_meter #(
        .WIN_LEN (WIN_LEN),
        .TARGET  (TARGET),
        .TOL     (TOL)
    ) u_meter (
        .clk      (clk),
        .rst      (rst),
        .enable   (mode_timer),
        .ref_tick (ref_tick),
        .step     (timer_step)
    );

    assign sel_step = mode_timer ? timer_step : uart_step;

    osctrim_trim_reg u_reg (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_wr),
        .wr_cfg (wr_cfg),
        .step   (sel_step),
        .cfg    (cfg_q)
    );

    assign trim_code  = cfg_q.trim;
    assign cfg_rdata  = pack_view(cfg_q);
    assign pll_active = cfg_q.pll_en && pll_allowed(hf_sel);
    assign lf_use_div = cfg_q.lf_div;
endmodule

// File: rtl/osctrim_ctrl_chk.sv
module osctrim_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       mode_timer,
    input logic       rx_frame_err,
    input logic       rx_data_err,
    input logic       cfg_wr,
    input logic [7:0] cfg_wdata,
    input logic [2:0] hf_sel,
    input logic [4:0] trim_code,
    input logic [7:0] cfg_rdata,
    input logic       pll_active,
    input logic       lf_use_div
);
    logic signed [5:0] trim_ext;
    assign trim_ext = {trim_code[4], trim_code};

    // R2
    a_r2_frame_dec: assert property (@(posedge clk) disable iff (rst)
        (!mode_timer && rx_frame_err && !rx_data_err && !cfg_wr && trim_code != 5'b10000)
        |=> trim_ext == $past(trim_ext) - 6'sd1);

    // R3
    a_r3_data_inc: assert property (@(posedge clk) disable iff (rst)
        (!mode_timer && rx_data_err && !rx_frame_err && !cfg_wr && trim_code != 5'b01111)
        |=> trim_ext == $past(trim_ext) + 6'sd1);

    // R4
    a_r4_frame_wins: assert property (@(posedge clk) disable iff (rst)
        (!mode_timer && rx_data_err && rx_frame_err && !cfg_wr && trim_code != 5'b10000)
        |=> trim_ext == $past(trim_ext) - 6'sd1);

    // R5
    a_r5_no_wrap_hi: assert property (@(posedge clk) disable iff (rst)
        (trim_code == 5'b01111 && !cfg_wr) |=> trim_code != 5'b10000);

    a_r5_no_wrap_lo: assert property (@(posedge clk) disable iff (rst)
        (trim_code == 5'b10000 && !cfg_wr) |=> trim_code != 5'b01111);

    // R8
    a_r8_quiet_hold: assert property (@(posedge clk) disable iff (rst)
        (!mode_timer && !rx_frame_err && !rx_data_err && !cfg_wr) |=> $stable(trim_code));

    // R9
    a_r9_write_wins: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> trim_code == $past(cfg_wdata[4:0]));

    a_r9_bit5_zero: assert property (@(posedge clk) disable iff (rst) !cfg_rdata[5]);

    // R10
    a_r10_pll_gate: assert property (@(posedge clk) disable iff (rst)
        pll_active |-> (cfg_rdata[6] && hf_sel[2:1] == 2'b11));

    // R11
    a_r11_lf_stable: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr |=> $stable(lf_use_div));
endmodule

bind osctrim_ctrl osctrim_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .mode_timer   (mode_timer),
    .rx_frame_err (rx_frame_err),
    .rx_data_err  (rx_data_err),
    .cfg_wr       (cfg_wr),
    .cfg_wdata    (cfg_wdata),
    .hf_sel       (hf_sel),
    .trim_code    (trim_code),
    .cfg_rdata    (cfg_rdata),
    .pll_active   (pll_active),
    .lf_use_div   (lf_use_div)
);

// File: tb/osctrim_ctrl_bench.sv
module osctrim_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WIN  = 16;
    localparam int TGT  = 64;
    localparam int TL   = 2;
    localparam int DMAX = 255;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_timer = 1'b0, rx_frame_err = 1'b0, rx_data_err = 1'b0;
    logic       ref_tick = 1'b0, cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [2:0] hf_sel = 3'd0;
    logic [4:0] trim_code;
    logic [7:0] cfg_rdata;
    logic       pll_active, lf_use_div;

    int checks = 0, fails = 0;
    int m_trim = 0, m_dev = 0, m_ref = 0;
    logic m_lf = 1'b0, m_pll = 1'b0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    osctrim_ctrl #(.WIN_LEN(WIN), .TARGET(TGT), .TOL(TL)) u_osctrim_ctrl (
        .clk(clk), .rst(rst), .mode_timer(mode_timer), .rx_frame_err(rx_frame_err),
        .rx_data_err(rx_data_err), .ref_tick(ref_tick), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .hf_sel(hf_sel), .trim_code(trim_code),
        .cfg_rdata(cfg_rdata), .pll_active(pll_active), .lf_use_div(lf_use_div)
    );

    function automatic int clamp_trim(int v);
        if (v > 15) return 15;
        if (v < -16) return -16;
        return v;
    endfunction

    function automatic logic [7:0] exp_view();
        logic [4:0] t;
        t = 5'(m_trim);
        return {m_lf, m_pll, 1'b0, t};
    endfunction

    task automatic check(string req, int act, int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    task automatic check_outputs();
        check(cur_req, int'($signed(trim_code)), m_trim);
        check("R9 view", int'(cfg_rdata), int'(exp_view()));
        check("R10 pll", int'(pll_active), int'(m_pll && (hf_sel == 3'd6 || hf_sel == 3'd7)));
        check("R11 lf", int'(lf_use_div), int'(m_lf));
    endtask

    // Apply one cycle of inputs and advance the reference model to the post-edge state.
    task automatic cyc(logic wr, logic [7:0] wd, logic md, logic fe, logic de, logic tk);
        int stp, dv;
        @(negedge clk);
        check_outputs();
        cfg_wr = wr; cfg_wdata = wd; mode_timer = md;
        rx_frame_err = fe; rx_data_err = de; ref_tick = tk;
        hf_sel = 3'($urandom_range(0, 7));
        stp = 0;
        if (!md) begin
            if (fe) stp = -1;
            else if (de) stp = 1;
            m_dev = 0; m_ref = 0;
        end else begin
            dv = (m_dev >= DMAX) ? DMAX : m_dev + 1;
            if (tk && m_ref == WIN - 1) begin
                if (dv > TGT + TL) stp = -1;
                else if (dv < TGT - TL) stp = 1;
                m_dev = 0; m_ref = 0;
            end else begin
                m_dev = dv;
                if (tk) m_ref++;
            end
        end
        m_trim = clamp_trim(m_trim + stp);
        if (wr) begin
            m_trim = int'($signed(wd[4:0]));
            m_lf = wd[7];
            m_pll = wd[6];
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic timer_run(int period, int ncyc);
        for (int i = 0; i < ncyc; i++)
            cyc(1'b0, 8'h00, 1'b1, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                (i % period) == period - 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", int'(cfg_rdata), 0);
        check("R1", int'(trim_code), 0);
        rst = 1'b0;
        cur_req = "R1";
        idle(2);

        cur_req = "R2";
        for (int i = 0; i < 4; i++) begin cyc(0, 8'h00, 0, 1, 0, 0); idle(1); end
        cur_req = "R3";
        for (int i = 0; i < 6; i++) cyc(0, 8'h00, 0, 0, 1, 0);
        cur_req = "R4";
        for (int i = 0; i < 3; i++) cyc(0, 8'h00, 0, 1, 1, 0);
        idle(1);

        cur_req = "R5";
        cyc(1, 8'h8F, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) cyc(0, 8'h00, 0, 0, 1, 0);
        cyc(1, 8'h50, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) cyc(0, 8'h00, 0, 1, 0, 0);
        idle(1);

        // R6 / R7: periods 3, 4, 5 give counts 48, 64, 80 around 64 +/- 2
        cur_req = "R6";
        cyc(1, 8'h00, 0, 0, 0, 0);
        timer_run(3, WIN * 3 * 2);
        cur_req = "R7";
        timer_run(4, WIN * 4 * 2);
        timer_run(5, WIN * 5 * 3);
        idle(2);

        // R8: wrong-source stimulus in each mode
        cur_req = "R8";
        for (int i = 0; i < 40; i++) cyc(0, 8'h00, 0, 0, 0, 1);
        timer_run(2, 20);
        idle(1);

        // R9: write alongside errors
        cur_req = "R9";
        cyc(1, 8'hE3, 0, 1, 0, 0);
        cyc(1, 8'h3D, 0, 0, 1, 0);
        cyc(1, 8'hFF, 0, 1, 1, 0);
        idle(1);

        cur_req = "R10";
        for (int i = 0; i < 16; i++) cyc(1'(i % 2), 8'($urandom), 0, 0, 0, 0);

        // R11 and mixed random traffic
        cur_req = "R11";
        for (int blk = 0; blk < 40; blk++) begin
            logic md;
            int per;
            md = 1'($urandom_range(0, 1));
            per = $urandom_range(2, 6);
            for (int i = 0; i < 150; i++)
                cyc(($urandom_range(0, 99) < 2), 8'($urandom), md,
                    ($urandom_range(0, 9) < 2), ($urandom_range(0, 9) < 3),
                    (i % per) == per - 1);
        end

        @(negedge clk);
        check_outputs();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule